// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog that sits on a simple single-cycle read/write port. A free-running timebase counter runs from reset and can be read at any time. When software arms the watchdog, an interval counter of `2^INTERVAL_BITS` clock cycles starts. The first time the interval runs out, the block sets a watchdog-state flag and pulses an interrupt. If software has not cleared that flag by the time the interval runs out again, the block pulses a system reset output and latches a reset-status flag. Both flags stay set until software writes a one to them. The full timeout is therefore two intervals.

Arming uses two enable bits that live in different registers. The watchdog counts while either bit is set, so one stray write cannot stop it. Software keeps the watchdog alive by writing the first register with the state bit set. When the `LOCK_ONCE` parameter is set, the enable bits cannot be cleared once the watchdog is running.

The register is chosen by address bits [3:2]. Reads are combinational from the current address, and writes take effect at the rising clock edge.

Top module: `twoStageWatchdog`

## Requirements
- R1: After reset, both control words read zero, the timebase reads zero, and `irqOut` and `sysRstOut` are low.
- R2: Address bits [3:2] select the register: 0 selects control word A, 1 selects control word B, 2 selects the timebase, and 3 reads zero. Control word A bits are: [3] reset-status, [2] watchdog-state, [1] enable-A, [0] a read-only copy of enable-B. Control word B bit [0] is enable-B. All other read bits are zero.
- R3: The timebase increments by exactly one every clock cycle, whether or not the watchdog is armed.
- R4: The interval counter runs while enable-A or enable-B is set. Setting either enable alone is enough. The counter is cleared whenever both enables are clear.
- R5: An interval expires on the clock edge that follows `2^INTERVAL_BITS` counted cycles. When an interval expires while the state flag is clear, the block sets the state flag and drives `irqOut` high for one cycle.
- R6: When an interval expires while the state flag is already set, the block drives `sysRstOut` high for one cycle and sets the reset-status flag. The state flag stays set.
- R7: Writing control word A with bit [2] = 1 clears the state flag and restarts the interval from zero. If such a write happens in the cycle where an expiry would occur, the write wins and no expiry event occurs.
- R8: Writing control word A with bit [3] = 1 clears the reset-status flag. A restart alone leaves the reset-status flag unchanged. A reset event in the same cycle as the clearing write wins, so the flag ends up set.
- R9: With `LOCK_ONCE` = 1, any write that would clear an enable bit is ignored while the watchdog is armed.
- R10: While both enables are clear, neither `irqOut` nor `sysRstOut` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 4 | Byte address; bits [3:2] select the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current `busAddr` |
| irqOut | output | 1 | One-cycle pulse on the first expiry |
| sysRstOut | output | 1 | One-cycle pulse on the second consecutive expiry |

## Verification
A wrong interval count shows up directly at the ports. The state bit and `irqOut` move by whole cycles away from the `2^INTERVAL_BITS` boundary, and a cycle-level model catches this on the edge where it happens. A flag that is lost or cleared at the wrong time appears on the next read of control word A, and also one interval later as a missing or extra `sysRstOut` pulse. An enable that leaks or is wrongly locked appears the same cycle in the read-back bits [1:0], and within one interval as unexpected expiry pulses. A stuck or skipping timebase is visible on any two consecutive reads.

// File: rtl/wdogPkg.sv
package wdogPkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [1:0] SEL_CTRL_A = 2'd0;
  localparam logic [1:0] SEL_CTRL_B = 2'd1;
  localparam logic [1:0] SEL_TBASE  = 2'd2;

  typedef struct packed {
    logic run;      // either enable set
    logic restart;  // write-one to state bit
    logic clrRst;   // write-one to reset-status bit
  } wdStrobe_t;
endpackage

// File: rtl/wdogCtrl.sv
module wdogCtrl
  import wdogPkg::*;
#(
  parameter bit LOCK_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [1:0]        regSel,
  input  logic [3:0]        wrBits,
  output logic              enA,
  output logic              enB,
  output wdStrobe_t         strobe
);
  logic wrCtrlA;
  logic wrCtrlB;
  logic armed;
  logic holdOn;

  assign wrCtrlA = busWrite && (regSel == SEL_CTRL_A);
  assign wrCtrlB = busWrite && (regSel == SEL_CTRL_B);
  assign armed   = enA || enB;
  assign holdOn  = LOCK_ONCE && armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enA <= 1'b0;
      enB <= 1'b0;
    end else begin
      if (wrCtrlA && (wrBits[1] || !holdOn)) enA <= wrBits[1];
      if (wrCtrlB && (wrBits[0] || !holdOn)) enB <= wrBits[0];
    end
  end

  always_comb begin
    strobe.run     = armed;
    strobe.restart = wrCtrlA && wrBits[2];
    strobe.clrRst  = wrCtrlA && wrBits[3];
  end
endmodule

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int unsigned INTERVAL_BITS = 16,
  parameter int unsigned TB_W          = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  wdStrobe_t       strobe,
  output logic [TB_W-1:0] timebase,
  output logic            stateFlag,
  output logic            rstFlag,
  output logic            irqPulse,
  output logic            rstPulse
);
  localparam logic [INTERVAL_BITS-1:0] CNT_LAST = '1;

  logic [INTERVAL_BITS-1:0] intCnt;
  logic                     expire;

  assign expire = strobe.run && (intCnt == CNT_LAST) && !strobe.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timebase <= '0;
    else       timebase <= timebase + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               intCnt <= '0;
    else if (!strobe.run || strobe.restart)  intCnt <= '0;
    else                                     intCnt <= intCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateFlag <= 1'b0;
      rstFlag   <= 1'b0;
      irqPulse  <= 1'b0;
      rstPulse  <= 1'b0;
    end else begin
      if (strobe.restart)  stateFlag <= 1'b0;
      else if (expire)     stateFlag <= 1'b1;
      if (expire && stateFlag) rstFlag <= 1'b1;
      else if (strobe.clrRst)  rstFlag <= 1'b0;
      irqPulse <= expire && !stateFlag;
      rstPulse <= expire && stateFlag;
    end
  end
endmodule

// File: rtl/twoStageWatchdog.sv
module twoStageWatchdog
  import wdogPkg::*;
#(
  parameter int unsigned INTERVAL_BITS = 16,
  parameter int unsigned TB_W          = 32,
  parameter bit          LOCK_ONCE     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [3:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              sysRstOut
);
  wdStrobe_t        strobe;
  logic             enA;
  logic             enB;
  logic             stateFlag;
  logic             rstFlag;
  logic [TB_W-1:0]  timebase;
  logic [1:0]       regSel;
  logic             unusedBits;

  assign regSel     = busAddr[3:2];
  assign unusedBits = ^{busAddr[1:0], busWdata[DATA_W-1:4]};

  wdogCtrl #(.LOCK_ONCE(LOCK_ONCE)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .regSel(regSel),
    .wrBits(busWdata[3:0]), .enA(enA), .enB(enB), .strobe(strobe)
  );

  wdogDatapath #(.INTERVAL_BITS(INTERVAL_BITS), .TB_W(TB_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timebase(timebase),
    .stateFlag(stateFlag), .rstFlag(rstFlag),
    .irqPulse(irqOut), .rstPulse(sysRstOut)
  );

  always_comb begin
    unique case (regSel)
      SEL_CTRL_A: busRdata = {{(DATA_W-4){1'b0}}, rstFlag, stateFlag, enA, enB};
      SEL_CTRL_B: busRdata = {{(DATA_W-1){1'b0}}, enB};
      SEL_TBASE:  busRdata = DATA_W'(timebase);
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdogChecker.sv
module wdogChecker #(
  parameter int unsigned TB_W      = 32,
  parameter bit          LOCK_ONCE = 1'b0
) (
  input logic            clk,
  input logic            rstN,
  input logic            irqOut,
  input logic            sysRstOut,
  input logic            stateFlag,
  input logic            rstFlag,
  input logic            enA,
  input logic            enB,
  input logic [TB_W-1:0] timebase
);
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            seen <= '0;
    else if (seen != 2'd3) seen <= seen + 1'b1;
  end

  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (seen != 2'd0) |-> (timebase == TB_W'($past(timebase) + 1'b1))); // R3
  AST_IRQ_SETS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> stateFlag); // R5
  AST_RST_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    sysRstOut |-> (rstFlag && stateFlag)); // R6
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sysRstOut |=> !sysRstOut); // R6
  AST_NO_DOUBLE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && sysRstOut)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(enA || enB) |=> !(irqOut || sysRstOut)); // R10

  generate
    if (LOCK_ONCE) begin : gLock
      AST_LOCK_A: assert property (@(posedge clk) disable iff (!rstN)
        enA |=> enA); // R9
      AST_LOCK_B: assert property (@(posedge clk) disable iff (!rstN)
        enB |=> enB); // R9
    end
  endgenerate
endmodule

bind twoStageWatchdog wdogChecker #(.TB_W(TB_W), .LOCK_ONCE(LOCK_ONCE)) uChk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .sysRstOut(sysRstOut),
  .stateFlag(stateFlag), .rstFlag(rstFlag), .enA(enA), .enB(enB),
  .timebase(timebase)
);

// File: tb/sim_twoStageWatchdog.sv
`timescale 1ns/1ps
module sim_twoStageWatchdog;
  localparam int unsigned IB = 4;
  localparam int unsigned NCYC = 1 << IB;

  typedef struct packed {
    logic        enA;
    logic        enB;
    logic        st;
    logic        rs;
    logic        irq;
    logic        srst;
    logic [31:0] cnt;
    logic [31:0] tb;
  } mdl_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1, srst0, srst1;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  mdl_t        m0, m1;

  always #2 clk = ~clk;

  twoStageWatchdog #(.INTERVAL_BITS(IB), .LOCK_ONCE(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdata0), .irqOut(irq0), .sysRstOut(srst0)
  );
  twoStageWatchdog #(.INTERVAL_BITS(IB), .LOCK_ONCE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdata1), .irqOut(irq1), .sysRstOut(srst1)
  );

  function automatic mdl_t step(mdl_t m, logic wr, logic [3:0] a, logic [31:0] d, bit lock);
    mdl_t n = m;
    bit armed = m.enA || m.enB;
    bit w0 = wr && (a[3:2] == 2'd0);
    bit w1 = wr && (a[3:2] == 2'd1);
    bit rsr = w0 && d[2];
    bit ov = armed && (m.cnt == NCYC - 1) && !rsr;
    n.tb = m.tb + 1;
    n.cnt = (!armed || rsr) ? 32'd0 : ((m.cnt + 1) % NCYC);
    if (rsr) n.st = 1'b0; else if (ov) n.st = 1'b1;
    if (ov && m.st) n.rs = 1'b1; else if (w0 && d[3]) n.rs = 1'b0;
    n.irq = ov && !m.st;
    n.srst = ov && m.st;
    if (w0 && (d[1] || !(lock && armed))) n.enA = d[1];
    if (w1 && (d[0] || !(lock && armed))) n.enB = d[0];
    return n;
  endfunction

  function automatic logic [31:0] rdModel(mdl_t m, logic [3:0] a);
    case (a[3:2])
      2'd0: return {28'd0, m.rs, m.st, m.enA, m.enB};
      2'd1: return {31'd0, m.enB};
      2'd2: return m.tb;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m0 = '0;
      m1 = '0;
    end else begin
      m0 = step(m0, busWrite, busAddr, busWdata, 1'b0);
      m1 = step(m1, busWrite, busAddr, busWdata, 1'b1);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    chk({tag, " rdata"}, rdata0, rdModel(m0, busAddr));
    chk({tag, " irq R5"}, {31'd0, irq0}, {31'd0, m0.irq});
    chk({tag, " sysRst R6"}, {31'd0, srst0}, {31'd0, m0.srst});
    chk("R9 locked rdata", rdata1, rdModel(m1, busAddr));
    chk("R9 locked irq", {31'd0, irq1}, {31'd0, m1.irq});
    chk("R9 locked sysRst", {31'd0, srst1}, {31'd0, m1.srst});
  endtask

  task automatic cyc(bit wr, logic [3:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    busWrite = wr;
    busAddr = a;
    busWdata = d;
    #1;
    compareAll(tag);
  endtask

  task automatic expectA(string tag, logic [31:0] exp);
    cyc(1'b0, 4'h0, 32'd0, tag);
    chk(tag, rdata0, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    logic [31:0] tbA;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    cyc(1'b0, 4'h0, 32'd0, "R1");
    chk("R1 ctrlA", rdata0, 32'd0);
    chk("R1 irq", {31'd0, irq0}, 32'd0);
    chk("R1 sysRst", {31'd0, srst0}, 32'd0);
    cyc(1'b0, 4'h4, 32'd0, "R1");
    chk("R1 ctrlB", rdata0, 32'd0);
    cyc(1'b0, 4'hC, 32'd0, "R2");
    chk("R2 unmapped reads zero", rdata0, 32'd0);

    // R3 timebase steps by one while disarmed
    cyc(1'b0, 4'h8, 32'd0, "R3");
    tbA = rdata0;
    cyc(1'b0, 4'h8, 32'd0, "R3");
    chk("R3 timebase step", rdata0, tbA + 1);

    // R4 enable-B alone arms; first expiry after NCYC cycles (R5)
    cyc(1'b1, 4'h4, 32'd1, "R4");
    repeat (NCYC - 1) cyc(1'b0, 4'h0, 32'd0, "R4");
    expectA("R4 before expiry", 32'h1);
    expectA("R4 enable-B alone expires", 32'h5);
    chk("R5 irq pulse", {31'd0, irq0}, 32'd1);

    // R7 restart clears the state flag
    cyc(1'b1, 4'h0, 32'h4, "R7");
    expectA("R7 state cleared", 32'h1);

    // R10 disarm: both enables clear, no events
    cyc(1'b1, 4'h4, 32'd0, "R10");
    repeat (3 * NCYC) cyc(1'b0, 4'h0, 32'd0, "R10");
    expectA("R10 disarmed quiet", 32'h0);

    // R5 / R6 two-stage expiry with both enables
    cyc(1'b1, 4'h0, 32'h2, "R5");
    cyc(1'b1, 4'h4, 32'h1, "R5");
    repeat (NCYC - 2) cyc(1'b0, 4'h0, 32'd0, "R5");
    expectA("R5 before first expiry", 32'h3);
    expectA("R5 first expiry", 32'h7);
    chk("R5 irq", {31'd0, irq0}, 32'd1);
    repeat (NCYC - 2) cyc(1'b0, 4'h0, 32'd0, "R6");
    expectA("R6 before second expiry", 32'h7);
    chk("R6 no reset yet", {31'd0, srst0}, 32'd0);
    expectA("R6 second expiry", 32'hF);
    chk("R6 reset pulse", {31'd0, srst0}, 32'd1);
    cyc(1'b0, 4'h0, 32'd0, "R6");
    chk("R6 reset single cycle", {31'd0, srst0}, 32'd0);

    // R8 restart keeps reset-status, write-one clears it
    cyc(1'b1, 4'h0, 32'h6, "R8");
    expectA("R8 restart keeps reset-status", 32'hB);
    cyc(1'b1, 4'h0, 32'hA, "R8");
    expectA("R8 write-one clears reset-status", 32'h3);

    // R7 restart in the expiry cycle wins
    cyc(1'b1, 4'h0, 32'h6, "R7");
    repeat (NCYC - 1) cyc(1'b0, 4'h0, 32'd0, "R7");
    cyc(1'b1, 4'h0, 32'h6, "R7");
    expectA("R7 restart beats expiry", 32'h3);
    chk("R7 no irq", {31'd0, irq0}, 32'd0);

    // R9 locked instance ignores disarm
    cyc(1'b1, 4'h0, 32'h0, "R9");
    cyc(1'b1, 4'h4, 32'h0, "R9");
    cyc(1'b0, 4'h0, 32'd0, "R9");
    chk("R9 locked enables held", {30'd0, rdata1[1:0]}, 32'h3);
    chk("R4 unlocked disarmed", {30'd0, rdata0[1:0]}, 32'h0);

    // R2 constrained random register traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [31:0] d;
      r = $urandom;
      d = $urandom & 32'h0000_000B;
      d[2] = ($urandom % 12) == 0;
      cyc((r % 5) == 0, {r[9:8], 2'b00}, d, "R2");
    end
    finishRun();
  end
endmodule